// File: doc/BRIEF.md
# Auto-Switching Receive DMA Controller

This block sits beside an on-chip receive frame buffer and decides when frames that are already stored should be moved to host memory by DMA, instead of being left for the host to read out. In normal operation, completed frames wait in the buffer. The DMA path switches on only when a new frame passes the address filter at a moment when the buffer no longer has room for a maximum-length frame. While DMA is on, the block moves the oldest completed frames to host memory first. This frees buffer space for the frame that is still arriving.

Each moved frame is written as a run of word-sized write beats over a request/grant interface. Frames are placed back to back in host memory. After each frame the block updates three host-readable registers: a frame count, the host start address of the frame and its byte length. It also sets a status flag that drives an interrupt. Reading the frame count clears the count, the flag and the interrupt. Once that read has happened and no completed frames are left waiting, the block turns DMA off. A frame still in flight then stays in on-chip RAM for the host.

Register selects on `reg_sel`: 0 = frame count, 1 = start address of the last moved frame, 2 = byte length of the last moved frame, 3 = status with bit 1 = DMA mode and bit 0 = frame-moved flag. A read returns its data on `reg_rdata` one cycle after `reg_rd`.

Top module: `rxq_autodma`

## Requirements
- R1: DMA mode turns on only in a cycle where `frm_accept` is high and `buf_free` is below 1518. A `buf_free` of 1518 or more at acceptance leaves DMA mode off.
- R2: Only completed frames (`frm_done` events) are moved, in completion order, oldest first. A frame that has been accepted but not yet completed is never moved.
- R3: A frame of N bytes is moved as ceil(N/4) write beats to consecutive word addresses. Each frame starts at the word after the previous frame's last beat, and the first frame after reset starts at the base address 0x4000.
- R4: After a frame's last beat is granted, the frame count increases by one, the start-address register holds that frame's first beat address, and the byte-length register holds N.
- R5: The frame-moved flag (status bit 0) and `dma_irq` are high from the cycle after a frame's last granted beat.
- R6: A read with `reg_sel` = 0 returns the count, then clears the count, the flag and `dma_irq`.
- R7: After a count read in DMA mode, DMA mode turns off once no completed frames are waiting and no frame is being moved. A frame that completes after that is not moved.
- R8: After reset, DMA mode is off, `dma_irq` is low, `dma_req` is low and the frame count reads 0.
- R9: If DMA mode turns on with no completed frames waiting, it stays on without issuing beats and moves the next frame that completes.
- R10: While `dma_req` is high and `dma_gnt` is low, `dma_req` and `dma_addr` hold their values.
- R11: `frame_release` pulses for exactly one cycle per moved frame, in the cycle of its last granted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_free | input | 12 | Free bytes in the receive buffer |
| frm_accept | input | 1 | Pulse: a new frame passed the address filter |
| frm_done | input | 1 | Pulse: a frame is fully stored |
| frm_len | input | 11 | Byte length of the frame completing with `frm_done` |
| dma_req | output | 1 | Write beat request toward host memory |
| dma_addr | output | 32 | Host byte address of the current beat |
| dma_last | output | 1 | Current beat is the last of its frame |
| dma_gnt | input | 1 | Host accepts the current beat |
| frame_release | output | 1 | Pulse: the oldest buffered frame has been moved out |
| dma_mode | output | 1 | DMA mode is active |
| dma_irq | output | 1 | Interrupt: a frame has been moved since the last count read |
| reg_rd | input | 1 | Host register read strobe |
| reg_sel | input | 2 | Register select |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |

## Verification
Some internal faults show up only slowly. A wrong mode decision or a stale read flag shows up as beats that appear when they should not, or never appear, within a few cycles of a filter event or a count read. A queue that loses order or takes a frame still in flight shows up instead as wrong beat counts and start addresses across a whole frame. The directed scenarios therefore compare every beat address against a host pointer that the bench keeps itself. They check each register after every group of frames and watch the ports for a quiet window after DMA turns off.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_SOF   = 2'd1,
        SEL_BYTES = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_MOVE = 1'b1
    } eng_state_e;

    function automatic logic is_count_read(logic rd, logic [1:0] sel);
        return rd && (reg_sel_e'(sel) == SEL_COUNT);
    endfunction

endpackage

// File: rtl/rxq_len_fifo.sv
module rxq_len_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   used;

    assign empty = (used == '0);
    assign full  = (used == (PW+1)'(DEPTH));
    assign head  = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop && !empty) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push && !full, pop && !empty})
                2'b10:   used <= used + 1'b1;
                2'b01:   used <= used - 1'b1;
                default: used <= used;
            endcase
        end
    end
endmodule

// File: rtl/rxq_mode_ctl.sv
module rxq_mode_ctl #(
    parameter int FREE_W    = 12,
    parameter int MAX_FRAME = 1518
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_accept,
    input  logic [FREE_W-1:0] buf_free,
    input  logic              cnt_read,
    input  logic              q_empty,
    input  logic              eng_idle,
    output logic              dma_on
);
    logic rd_seen;
    logic low_room;

    assign low_room = (buf_free < FREE_W'(MAX_FRAME));

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_on  <= 1'b0;
            rd_seen <= 1'b0;
        end else if (!dma_on) begin
            rd_seen <= 1'b0;
            if (frm_accept && low_room) begin
                dma_on <= 1'b1;
            end
        end else begin
            if (rd_seen && q_empty && eng_idle) begin
                dma_on  <= 1'b0;
                rd_seen <= 1'b0;
            end else if (cnt_read) begin
                rd_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxq_xfer_eng.sv
module rxq_xfer_eng
    import rxq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 11,
    parameter int WORD_BYTES = 4,
    parameter logic [ADDR_W-1:0] HOST_BASE = 32'h0000_4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_on,
    input  logic              q_empty,
    input  logic [LEN_W-1:0]  q_head,
    output logic              q_pop,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              dma_last,
    input  logic              dma_gnt,
    output logic              done,
    output logic [LEN_W-1:0]  done_len,
    output logic [ADDR_W-1:0] done_sof,
    output logic              eng_idle
);
    localparam int WB_SH = $clog2(WORD_BYTES);

    eng_state_e        state;
    logic [ADDR_W-1:0] host_ptr, beat_addr, cur_sof;
    logic [LEN_W:0]    beats_left, len_pad, words;
    logic [LEN_W-1:0]  cur_len;

    assign len_pad  = {1'b0, q_head} + (LEN_W+1)'(WORD_BYTES-1);
    assign words    = ((len_pad >> WB_SH) == '0) ? (LEN_W+1)'(1) : (len_pad >> WB_SH);
    assign eng_idle = (state == ENG_IDLE);
    assign q_pop    = eng_idle && dma_on && !q_empty;
    assign dma_req  = (state == ENG_MOVE);
    assign dma_addr = beat_addr;
    assign dma_last = dma_req && (beats_left == (LEN_W+1)'(1));
    assign done     = dma_last && dma_gnt;
    assign done_len = cur_len;
    assign done_sof = cur_sof;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ENG_IDLE;
            host_ptr   <= HOST_BASE;
            beat_addr  <= HOST_BASE;
            cur_sof    <= HOST_BASE;
            cur_len    <= '0;
            beats_left <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (q_pop) begin
                        cur_len    <= q_head;
                        cur_sof    <= host_ptr;
                        beat_addr  <= host_ptr;
                        beats_left <= words;
                        state      <= ENG_MOVE;
                    end
                end
                ENG_MOVE: begin
                    if (dma_gnt) begin
                        beat_addr  <= beat_addr + ADDR_W'(WORD_BYTES);
                        beats_left <= beats_left - 1'b1;
                        if (dma_last) begin
                            host_ptr <= beat_addr + ADDR_W'(WORD_BYTES);
                            state    <= ENG_IDLE;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxq_autodma.sv
module rxq_autodma
    import rxq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 11,
    parameter int FREE_W     = 12,
    parameter int CNT_W      = 8,
    parameter int WORD_BYTES = 4,
    parameter int QDEPTH     = 4,
    parameter int MAX_FRAME  = 1518,
    parameter logic [ADDR_W-1:0] HOST_BASE = 32'h0000_4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREE_W-1:0] buf_free,
    input  logic              frm_accept,
    input  logic              frm_done,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              dma_last,
    input  logic              dma_gnt,
    output logic              frame_release,
    output logic              dma_mode,
    output logic              dma_irq,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    output logic [ADDR_W-1:0] reg_rdata
);
    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] sof;
        logic [LEN_W-1:0]  bytes;
        logic              flag;
    } dma_regs_t;

    dma_regs_t         regs;
    logic              cnt_read, q_empty, q_full, q_pop, eng_idle, done;
    logic [LEN_W-1:0]  q_head, done_len;
    logic [ADDR_W-1:0] done_sof;

    assign cnt_read      = is_count_read(reg_rd, reg_sel);
    assign frame_release = done;
    assign dma_irq       = regs.flag;

    rxq_len_fifo #(.DEPTH(QDEPTH), .W(LEN_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(frm_done), .push_data(frm_len),
        .pop(q_pop), .head(q_head),
        .empty(q_empty), .full(q_full)
    );

    rxq_mode_ctl #(.FREE_W(FREE_W), .MAX_FRAME(MAX_FRAME)) u_mode (
        .clk(clk), .rst(rst),
        .frm_accept(frm_accept), .buf_free(buf_free),
        .cnt_read(cnt_read), .q_empty(q_empty), .eng_idle(eng_idle),
        .dma_on(dma_mode)
    );

    rxq_xfer_eng #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W),
        .WORD_BYTES(WORD_BYTES), .HOST_BASE(HOST_BASE)
    ) u_eng (
        .clk(clk), .rst(rst),
        .dma_on(dma_mode), .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_last(dma_last),
        .dma_gnt(dma_gnt),
        .done(done), .done_len(done_len), .done_sof(done_sof),
        .eng_idle(eng_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regs      <= '0;
            reg_rdata <= '0;
        end else begin
            if (cnt_read) begin
                regs.count <= done ? CNT_W'(1) : '0;
            end else if (done && (regs.count != '1)) begin
                regs.count <= regs.count + 1'b1;
            end
            if (done) begin
                regs.sof   <= done_sof;
                regs.bytes <= done_len;
            end
            regs.flag <= done | (regs.flag & ~cnt_read);

            if (reg_rd) begin
                case (reg_sel_e'(reg_sel))
                    SEL_COUNT: reg_rdata <= {{(ADDR_W-CNT_W){1'b0}}, regs.count};
                    SEL_SOF:   reg_rdata <= regs.sof;
                    SEL_BYTES: reg_rdata <= {{(ADDR_W-LEN_W){1'b0}}, regs.bytes};
                    default:   reg_rdata <= {{(ADDR_W-2){1'b0}}, dma_mode, regs.flag};
                endcase
            end
        end
    end
endmodule

// File: rtl/rxq_autodma_chk.sv
module rxq_autodma_chk #(
    parameter int ADDR_W    = 32,
    parameter int FREE_W    = 12,
    parameter int MAX_FRAME = 1518
) (
    input logic              clk,
    input logic              rst,
    input logic [FREE_W-1:0] buf_free,
    input logic              frm_accept,
    input logic              dma_req,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              dma_gnt,
    input logic              frame_release,
    input logic              dma_mode,
    input logic              dma_irq,
    input logic              reg_rd,
    input logic [1:0]        reg_sel
);
    AST_ENTRY_LOW_ROOM: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_mode) |-> ($past(frm_accept) && ($past(buf_free) < FREE_W'(MAX_FRAME)))); // R1

    AST_RELEASE_IN_DMA: assert property (@(posedge clk) disable iff (rst)
        frame_release |-> dma_mode); // R2

    AST_IRQ_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        frame_release |=> dma_irq); // R5

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel == 2'd0 && !frame_release) |=> !dma_irq); // R6

    AST_NO_REQ_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        !dma_mode |-> !dma_req); // R7

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_gnt) |=> (dma_req && $stable(dma_addr))); // R10

    AST_RELEASE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        frame_release |-> (dma_req && dma_gnt)); // R11
endmodule

bind rxq_autodma rxq_autodma_chk #(
    .ADDR_W(ADDR_W), .FREE_W(FREE_W), .MAX_FRAME(MAX_FRAME)
) u_chk (
    .clk(clk), .rst(rst), .buf_free(buf_free), .frm_accept(frm_accept),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_gnt(dma_gnt),
    .frame_release(frame_release), .dma_mode(dma_mode), .dma_irq(dma_irq),
    .reg_rd(reg_rd), .reg_sel(reg_sel)
);

// File: tb/test_rxq_autodma.sv
module test_rxq_autodma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] buf_free = 12'd4000;
    logic        frm_accept = 1'b0;
    logic        frm_done = 1'b0;
    logic [10:0] frm_len = '0;
    logic        dma_req, dma_last, dma_gnt, frame_release, dma_mode, dma_irq;
    logic [31:0] dma_addr, reg_rdata;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_sel = '0;

    int errors = 0;
    int checks = 0;
    int beat_n = 0;
    int rel_n = 0;
    logic [31:0] beat_log [256];
    logic [31:0] exp_ptr = 32'h0000_4000;
    logic gnt_en = 1'b1;

    assign dma_gnt = gnt_en;

    always #5 clk = ~clk;

    rxq_autodma i_rxq_autodma (
        .clk(clk), .rst(rst), .buf_free(buf_free), .frm_accept(frm_accept),
        .frm_done(frm_done), .frm_len(frm_len),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_last(dma_last),
        .dma_gnt(dma_gnt), .frame_release(frame_release),
        .dma_mode(dma_mode), .dma_irq(dma_irq),
        .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
    );

    always @(negedge clk) begin
        if (!rst && dma_req && dma_gnt) begin
            if (beat_n < 256) beat_log[beat_n] = dma_addr;
            beat_n++;
        end
        if (!rst && frame_release) rel_n++;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic accept(logic [11:0] free);
        @(negedge clk);
        frm_accept = 1'b1;
        buf_free   = free;
        @(negedge clk);
        frm_accept = 1'b0;
        buf_free   = 12'd4000;
    endtask

    task automatic complete(logic [10:0] len);
        @(negedge clk);
        frm_done = 1'b1;
        frm_len  = len;
        @(negedge clk);
        frm_done = 1'b0;
    endtask

    task automatic host_read(logic [1:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_rd  = 1'b1;
        reg_sel = sel;
        @(negedge clk);
        reg_rd  = 1'b0;
        val     = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R8 mode after reset", {31'b0, dma_mode}, 0);
        chk("R8 irq after reset", {31'b0, dma_irq}, 0);
        chk("R8 req after reset", {31'b0, dma_req}, 0);
        host_read(2'd0, v);
        chk("R8 count after reset", v, 0);
    endtask

    task automatic t_no_trigger;
        int b0;
        b0 = beat_n;
        complete(11'd100);
        complete(11'd61);
        accept(12'd1600);
        idle(3);
        chk("R1 free 1600 keeps mode off", {31'b0, dma_mode}, 0);
        accept(12'd1518);
        idle(3);
        chk("R1 free 1518 keeps mode off", {31'b0, dma_mode}, 0);
        chk("R1 no beats without mode", beat_n - b0, 0);
    endtask

    task automatic t_switch_on;
        int b0, r0;
        logic [31:0] v;
        b0 = beat_n; r0 = rel_n;
        gnt_en = 1'b0;
        accept(12'd1000);
        chk("R1 low room turns mode on", {31'b0, dma_mode}, 1);
        idle(6);
        chk("R10 req held while stalled", {31'b0, dma_req}, 1);
        chk("R10 addr held while stalled", dma_addr, exp_ptr);
        chk("R10 no beat while stalled", beat_n - b0, 0);
        gnt_en = 1'b1;
        idle(80);
        chk("R3 beats for 100 and 61 bytes", beat_n - b0, 41);
        chk("R2 oldest frame first addr", beat_log[b0], exp_ptr);
        chk("R3 last beat of first frame", beat_log[b0+24], exp_ptr + 32'd96);
        chk("R3 second frame back to back", beat_log[b0+25], exp_ptr + 32'd100);
        chk("R3 last beat of second frame", beat_log[b0+40], exp_ptr + 32'd160);
        chk("R11 one release per frame", rel_n - r0, 2);
        chk("R5 irq after transfer", {31'b0, dma_irq}, 1);
        host_read(2'd1, v);
        chk("R4 start address register", v, exp_ptr + 32'd100);
        host_read(2'd2, v);
        chk("R4 byte length register", v, 61);
        host_read(2'd3, v);
        chk("R5 status mode and flag", v, 3);
        exp_ptr = exp_ptr + 32'd164;
        host_read(2'd0, v);
        chk("R4 frame count two", v, 2);
        chk("R6 irq cleared by count read", {31'b0, dma_irq}, 0);
        idle(3);
        chk("R7 mode off after read", {31'b0, dma_mode}, 0);
        host_read(2'd0, v);
        chk("R6 count cleared", v, 0);
        b0 = beat_n;
        complete(11'd200);
        idle(30);
        chk("R7 late frame stays buffered", beat_n - b0, 0);
        chk("R7 no irq for late frame", {31'b0, dma_irq}, 0);
    endtask

    task automatic t_second_burst;
        int b0;
        logic [31:0] v;
        b0 = beat_n;
        accept(12'd500);
        idle(70);
        chk("R2 leftover frame moved", beat_n - b0, 50);
        chk("R3 continues after previous", beat_log[b0], exp_ptr);
        host_read(2'd1, v);
        chk("R4 start of 200-byte frame", v, exp_ptr);
        host_read(2'd0, v);
        chk("R4 count one", v, 1);
        exp_ptr = exp_ptr + 32'd200;
        idle(3);
        chk("R7 mode off after second read", {31'b0, dma_mode}, 0);
    endtask

    task automatic t_wait_empty;
        int b0;
        logic [31:0] v;
        b0 = beat_n;
        accept(12'd100);
        idle(20);
        chk("R9 mode held with empty queue", {31'b0, dma_mode}, 1);
        chk("R9 no beats with empty queue", beat_n - b0, 0);
        complete(11'd7);
        idle(10);
        chk("R9 waiting frame moved in 2 beats", beat_n - b0, 2);
        chk("R3 7-byte frame address", beat_log[b0+1], exp_ptr + 32'd4);
        host_read(2'd2, v);
        chk("R4 length of 7-byte frame", v, 7);
        host_read(2'd0, v);
        chk("R6 count read returns one", v, 1);
        exp_ptr = exp_ptr + 32'd8;
        idle(3);
        chk("R7 exit after waiting burst", {31'b0, dma_mode}, 0);
    endtask

    task automatic t_exit_no_frames;
        int b0;
        logic [31:0] v;
        b0 = beat_n;
        accept(12'd10);
        chk("R1 re-entry", {31'b0, dma_mode}, 1);
        host_read(2'd0, v);
        chk("R6 empty count", v, 0);
        idle(3);
        chk("R7 exit with nothing pending", {31'b0, dma_mode}, 0);
        chk("R7 no beats on empty exit", beat_n - b0, 0);
        chk("R5 irq stays low", {31'b0, dma_irq}, 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_no_trigger();
        t_switch_on();
        t_second_burst();
        t_wait_empty();
        t_exit_no_frames();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule